// File: doc/BRIEF.md
# Call Stack Trace Buffer

This block keeps a bounded record of the active call chain for a debugger. When the core reports a call, the block saves two words for the new level: the address of the calling instruction and the address the call jumps to. When the core reports a return, the newest level is discarded. A debug read port can read the current depth and every stored word at any time, so a debugger can rebuild the call chain while the core is halted or running.

The push and pop strobes are single-cycle event pins and have no back-pressure. A push that arrives when the buffer is full is dropped. The core never waits on this block. Which instructions count as calls or returns is decided outside the block.

Word storage has no reset. Only the depth counter and the read register are cleared. Words above the current depth keep their old values until a later push writes over them.

Top module: `call_trace_buf`

## Requirements
- R1: After reset the depth is 0 and the debug read data is 0.
- R2: A push with no pop, at depth c < DEPTH, stores pc_i in word 2c and npc_i in word 2c+1, then sets the depth to c+1.
- R3: A push with no pop at depth DEPTH changes neither the depth nor any stored word, and the depth never exceeds DEPTH.
- R4: A pop at nonzero depth lowers the depth by one, and the popped level's words stay readable.
- R5: A pop at depth 0 leaves the depth at 0.
- R6: When push and pop are both high in one cycle, the push is ignored: no word is written, and the pop acts as in R4 and R5.
- R7: Debug address 0 returns the depth, zero-extended, on dbg_rdata_o one cycle after the address is presented.
- R8: Debug address k+1 returns stored word k (word 2c is the pc of level c, word 2c+1 its npc), one cycle after the address is presented.
- R9: Debug addresses above 2*DEPTH return 0 one cycle later.
- R10: A push after a pop writes over the words of the reused level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_i | input | 1 | Call event strobe |
| pop_i | input | 1 | Return event strobe |
| pc_i | input | WORD_W | Address of the calling instruction |
| npc_i | input | WORD_W | Call target address |
| dbg_addr_i | input | ADDR_W | Debug read address (0 = depth, k+1 = word k) |
| dbg_rdata_o | output | WORD_W | Debug read data, one cycle of latency |

## Verification
The assertions check the depth counter on every cycle: its upper bound, the increment on a push, the decrement on a pop, no change on a pop at zero, and pop priority. They also check that the read port returns the depth at address 0 and zero above the word range. Only the bench's scenarios can show that words land at the correct indices, that a dropped or overridden push writes nothing, and that popped levels keep their contents until a later push writes over them. The bench does this by comparing every read against a behavioural model.

// File: rtl/ctb_pkg.sv
package ctb_pkg;
  typedef enum logic [1:0] {
    CTB_IDLE = 2'd0,
    CTB_PUSH = 2'd1,
    CTB_POP  = 2'd2
  } ctb_op_e;
endpackage

// File: rtl/ctb_depth_ctrl.sv
module ctb_depth_ctrl #(
  parameter int DEPTH = 32,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  logic             pop_i,
  output logic [CNT_W-1:0] depth_o,
  output logic             wr_en_o,
  output logic [CNT_W-1:0] wr_lvl_o
);
  import ctb_pkg::*;

  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic [CNT_W-1:0] depth_q;
  ctb_op_e          op;

  // pop wins over push; saturate at both ends
  always_comb begin
    op = CTB_IDLE;
    if (pop_i) begin
      if (depth_q != '0) op = CTB_POP;
    end else if (push_i && (depth_q < FULL)) begin
      op = CTB_PUSH;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      depth_q <= '0;
    end else begin
      unique case (op)
        CTB_PUSH: depth_q <= depth_q + 1'b1;
        CTB_POP:  depth_q <= depth_q - 1'b1;
        default:  depth_q <= depth_q;
      endcase
    end
  end

  assign depth_o  = depth_q;
  assign wr_en_o  = (op == CTB_PUSH);
  assign wr_lvl_o = depth_q;
endmodule

// File: rtl/ctb_store.sv
module ctb_store #(
  parameter int DEPTH  = 32,
  parameter int WORD_W = 64,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              wr_en_i,
  input  logic [CNT_W-1:0]  wr_lvl_i,
  input  logic [WORD_W-1:0] pc_i,
  input  logic [WORD_W-1:0] npc_i,
  output logic [WORD_W-1:0] words_o [2*DEPTH]
);
  for (genvar g = 0; g < DEPTH; g++) begin : g_level
    logic [WORD_W-1:0] pc_q;
    logic [WORD_W-1:0] npc_q;
    logic              sel;

    assign sel = wr_en_i && (wr_lvl_i == CNT_W'(g));

    always_ff @(posedge clk) begin
      if (sel) begin
        pc_q  <= pc_i;
        npc_q <= npc_i;
      end
    end

    assign words_o[2*g]     = pc_q;
    assign words_o[2*g + 1] = npc_q;
  end
endmodule

// File: rtl/ctb_rd_port.sv
module ctb_rd_port #(
  parameter int DEPTH  = 32,
  parameter int WORD_W = 64,
  parameter int CNT_W  = $clog2(DEPTH + 1),
  parameter int ADDR_W = $clog2(2*DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  depth_i,
  input  logic [WORD_W-1:0] words_i [2*DEPTH],
  output logic [WORD_W-1:0] rdata_o
);
  localparam int NWORDS = 2 * DEPTH;
  localparam int IDX_W  = (NWORDS > 1) ? $clog2(NWORDS) : 1;

  logic [IDX_W-1:0]  idx;
  logic [WORD_W-1:0] rd_nxt;

  always_comb begin
    idx    = IDX_W'(addr_i - 1'b1);
    rd_nxt = '0;
    if (addr_i == '0)
      rd_nxt = WORD_W'(depth_i);
    else if (addr_i <= ADDR_W'(NWORDS))
      rd_nxt = words_i[idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_o <= '0;
    else        rdata_o <= rd_nxt;
  end
endmodule

// File: rtl/call_trace_buf.sv
module call_trace_buf #(
  parameter int DEPTH  = 32,
  parameter int WORD_W = 64,
  parameter int CNT_W  = $clog2(DEPTH + 1),
  parameter int ADDR_W = $clog2(2*DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_i,
  input  logic              pop_i,
  input  logic [WORD_W-1:0] pc_i,
  input  logic [WORD_W-1:0] npc_i,
  input  logic [ADDR_W-1:0] dbg_addr_i,
  output logic [WORD_W-1:0] dbg_rdata_o
);
  logic [CNT_W-1:0]  depth;
  logic              wr_en;
  logic [CNT_W-1:0]  wr_lvl;
  logic [WORD_W-1:0] words [2*DEPTH];

  ctb_depth_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .push_i(push_i), .pop_i(pop_i),
    .depth_o(depth), .wr_en_o(wr_en), .wr_lvl_o(wr_lvl)
  );

  ctb_store #(.DEPTH(DEPTH), .WORD_W(WORD_W), .CNT_W(CNT_W)) u_store (
    .clk(clk), .wr_en_i(wr_en), .wr_lvl_i(wr_lvl),
    .pc_i(pc_i), .npc_i(npc_i), .words_o(words)
  );

  ctb_rd_port #(.DEPTH(DEPTH), .WORD_W(WORD_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .addr_i(dbg_addr_i), .depth_i(depth),
    .words_i(words), .rdata_o(dbg_rdata_o)
  );
endmodule

// File: rtl/ctb_checker.sv
module ctb_checker #(
  parameter int DEPTH  = 32,
  parameter int WORD_W = 64,
  parameter int CNT_W  = $clog2(DEPTH + 1),
  parameter int ADDR_W = $clog2(2*DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              push_i,
  input logic              pop_i,
  input logic [ADDR_W-1:0] dbg_addr_i,
  input logic [WORD_W-1:0] dbg_rdata_o,
  input logic [CNT_W-1:0]  depth
);
  localparam logic [CNT_W-1:0]  FULL   = CNT_W'(DEPTH);
  localparam logic [ADDR_W-1:0] LAST_A = ADDR_W'(2*DEPTH);

  assert_depth_limit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    depth <= FULL);

  assert_full_push_dropped_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !pop_i && depth == FULL) |=> $stable(depth));

  assert_push_grows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !pop_i && depth < FULL) |=> depth == $past(depth) + 1'b1);

  assert_pop_shrinks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && depth != '0) |=> depth == $past(depth) - 1'b1);

  assert_pop_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && depth == '0) |=> depth == '0);

  assert_pop_priority_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && push_i && depth == '0) |=> $stable(depth));

  assert_rd_depth_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_addr_i == '0) |=> dbg_rdata_o == WORD_W'($past(depth)));

  assert_rd_oob_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_addr_i > LAST_A) |=> dbg_rdata_o == '0);
endmodule

bind call_trace_buf ctb_checker #(
  .DEPTH(DEPTH), .WORD_W(WORD_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .push_i(push_i), .pop_i(pop_i),
  .dbg_addr_i(dbg_addr_i), .dbg_rdata_o(dbg_rdata_o), .depth(depth)
);

// File: tb/call_trace_buf_tb_top.sv
`timescale 1ns/1ps
module call_trace_buf_tb_top;
  localparam int DEPTH  = 32;
  localparam int WORD_W = 64;
  localparam int ADDR_W = $clog2(2*DEPTH + 1);
  localparam int NW     = 2 * DEPTH;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              push = 1'b0, pop = 1'b0;
  logic [WORD_W-1:0] pc_in = '0, npc_in = '0;
  logic [ADDR_W-1:0] addr_in = '0;
  logic [WORD_W-1:0] rdata;

  int total = 0, bad = 0, cycles = 0;
  bit done = 0;
  string phase = "R1";

  always #2 clk = ~clk;

  call_trace_buf #(.DEPTH(DEPTH), .WORD_W(WORD_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .push_i(push), .pop_i(pop),
    .pc_i(pc_in), .npc_i(npc_in), .dbg_addr_i(addr_in), .dbg_rdata_o(rdata)
  );

  // behavioural reference
  int                m_cnt;
  logic [WORD_W-1:0] m_mem [NW];
  bit                m_ok  [NW];
  logic [WORD_W-1:0] m_exp;
  bit                m_exp_ok;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_exp = '0; m_exp_ok = 1;
      for (int i = 0; i < NW; i++) m_ok[i] = 0;
    end else begin
      int a;
      a = int'(addr_in);
      if (a == 0) begin m_exp = WORD_W'(m_cnt); m_exp_ok = 1; end
      else if (a <= NW) begin m_exp = m_mem[a-1]; m_exp_ok = m_ok[a-1]; end
      else begin m_exp = '0; m_exp_ok = 1; end
      if (pop) begin
        if (m_cnt > 0) m_cnt--;
      end else if (push && m_cnt < DEPTH) begin
        m_mem[2*m_cnt] = pc_in; m_mem[2*m_cnt+1] = npc_in;
        m_ok[2*m_cnt] = 1; m_ok[2*m_cnt+1] = 1;
        m_cnt++;
      end
    end
  end

  task automatic check(input logic [WORD_W-1:0] act, input logic [WORD_W-1:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    if (m_exp_ok && !done) check(rdata, m_exp, phase);
  end

  task automatic finish_up();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_up();
    end
  end

  task automatic drive(input logic ps, input logic pp, input logic [WORD_W-1:0] pc,
                       input logic [WORD_W-1:0] npc, input int a);
    @(negedge clk);
    push = ps; pop = pp; pc_in = pc; npc_in = npc; addr_in = ADDR_W'(a);
  endtask

  task automatic rd(input int a, input logic [WORD_W-1:0] exp, input string tag);
    drive(0, 0, '0, '0, a);
    @(negedge clk);
    check(rdata, exp, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(rdata, '0, "R1");
    rst_n = 1'b1;
    rd(0, 0, "R1");

    phase = "R2";
    for (int i = 0; i < 3; i++) drive(1, 0, 64'h100 + i, 64'h200 + i, 0);
    rd(1, 64'h100, "R2");
    rd(2, 64'h200, "R2");
    rd(6, 64'h202, "R2");
    rd(0, 3, "R2");

    phase = "R4";
    drive(0, 1, '0, '0, 0);
    drive(0, 1, '0, '0, 0);
    rd(0, 1, "R4");
    rd(3, 64'h101, "R4");

    phase = "R5";
    for (int i = 0; i < 3; i++) drive(0, 1, '0, '0, 0);
    rd(0, 0, "R5");

    phase = "R6";
    drive(1, 1, 64'hBAD0, 64'hBAD1, 0);
    rd(0, 0, "R6");
    rd(1, 64'h100, "R6");
    drive(1, 0, 64'hA0, 64'hA1, 0);
    drive(1, 1, 64'hBAD2, 64'hBAD3, 0);
    rd(0, 0, "R6");
    rd(3, 64'h101, "R6");

    phase = "R10";
    rd(1, 64'hA0, "R10");
    drive(1, 0, 64'hAAA, 64'hBBB, 0);
    rd(1, 64'hAAA, "R10");
    rd(2, 64'hBBB, "R10");

    phase = "R3";
    for (int l = 1; l < DEPTH; l++) drive(1, 0, 64'h1000 + l, 64'h2000 + l, 0);
    for (int i = 0; i < 3; i++) drive(1, 0, 64'hDEAD, 64'hBEEF, 0);
    rd(0, DEPTH, "R3");
    rd(NW, 64'h2000 + DEPTH - 1, "R3");
    rd(NW - 1, 64'h1000 + DEPTH - 1, "R3");

    phase = "R9";
    rd(NW + 1, 0, "R9");
    rd((1 << ADDR_W) - 1, 0, "R9");

    phase = "R8";
    for (int a = 1; a <= NW; a++) drive(0, 0, '0, '0, a);
    rd(5, 64'h1002, "R8");

    phase = "R7";
    for (int i = 0; i < DEPTH; i++) drive(0, 1, '0, '0, 0);
    rd(0, 0, "R7");
    rd(NW, 64'h2000 + DEPTH - 1, "R4");

    repeat (2) @(negedge clk);
    finish_up();
  end
endmodule